// File: doc/BRIEF.md
# Serial-Fed Telemetry Mailbox with Fill Code

This block sits between a flight computer's serial output and the frame builder of a telemetry encoder. The computer side sends two serial streams, each with its own enable and each clocked by a companion clock. One stream carries a 16-bit data word and the other an 8-bit slot address. The block turns both streams into parallel words. It then stores each data word in a 128-slot mailbox at the slot named by the most recent address. Words arrive whenever the computer produces them, and a later word for a slot replaces the earlier one.

A formatter on its own clock pulls bytes out of the mailbox in a fixed order. Each request returns one byte, high byte before low byte, and moves on through the slots in turn. A frame-start pulse sends the scan back to slot 0. A slot that holds zero is reported as an alternating fill byte, so an analyst can spot missing data at a glance. When no valid write arrives during a whole major frame, every byte is reported as fill until a write arrives again.

When a write and a read land on the same slot in the same cycle, the read returns the complete old word and the new word is stored in that cycle. The next read then sees the new word.

Top module: `tlm_mailbox`

## Requirements
- R1: Each serial stream is shifted in most significant bit first, one bit per write-clock edge while its enable is high. The value is taken when the enable drops: 16 bits for data, 8 bits for address.
- R2: Each completed data word is stored at the last completed address. An address stays in force for later data words until a new address arrives.
- R3: A request (rd_req high at a read-clock edge) returns one byte, and out_valid is high for exactly the following cycle. out_byte changes only after a request. The scan runs through byte positions 0 to 255 and wraps to 0. Position p reads slot p/2: an even p gives bits 15:8 and an odd p gives bits 7:0.
- R4: frame_start sets the scan position to 0 and takes priority over the pointer. A request in the same cycle reads position 0, and the next request reads position 1.
- R5: When the stored word is 16'h0000, both of its bytes read as 8'hAA. A 8'h00 byte of a non-zero word is passed unchanged.
- R6: A window runs between two frame_start pulses. If no valid write arrived in that window, reads return 8'hAA from the closing frame_start until the next valid write. The block comes out of reset in this fill state.
- R7: A write whose address is 128 or above is dropped. It changes no slot and does not count as activity.
- R8: When a read and a write to the same slot fall in the same read-clock cycle, the read returns the old complete word. The following read returns the new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Clock of the serial input streams |
| wrst_n | input | 1 | Active-low asynchronous reset, write side |
| data_sin | input | 1 | Serial data bit |
| data_en | input | 1 | High while data bits are being shifted |
| addr_sin | input | 1 | Serial address bit |
| addr_en | input | 1 | High while address bits are being shifted |
| rclk | input | 1 | Clock of the reader |
| rrst_n | input | 1 | Active-low asynchronous reset, read side |
| frame_start | input | 1 | Major-frame start: restarts the scan and the activity window |
| rd_req | input | 1 | Request for the next byte |
| out_byte | output | 8 | Returned byte, or the 8'hAA fill byte |
| out_valid | output | 1 | High in the cycle after a request |

## Verification
Several corner cases are targeted, each with the fault it would expose:
- **Same-slot collision:** a write is placed exactly in the cycle of a read of the same slot. A design that forwarded the new word, or mixed the two words, would show the new high byte too early.
- **Silent windows:** windows are built with no writes and with only out-of-range writes. A design that failed to go silent, or that counted a dropped write as activity, would return stored data instead of fill.
- **Byte order and zero handling:** zero words and words with a single zero byte are read back. A design that swapped the byte order, or that filled a single zero byte, would return wrong values.
- **Scan position:** reads are issued across the 255-to-0 wrap and at frame_start. An off-by-one pointer would return the wrong position.

// File: rtl/tlm_mbox_pkg.sv
package tlm_mbox_pkg;
  localparam int unsigned MB_DATA_W = 16;
  localparam int unsigned MB_ADDR_W = 8;
  localparam int unsigned MB_DEPTH  = 128;
endpackage

// File: rtl/tlm_rst_sync.sv
module tlm_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_n = sync_q;
endmodule

// File: rtl/tlm_deser.sv
module tlm_deser #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sin,
  input  logic         en,
  output logic         done,
  output logic [W-1:0] val
);
  logic [W-1:0] sh_q, sh_nx;
  logic [W-1:0] val_q, val_nx;
  logic         en_q;
  logic         done_q;
  logic         fall;

  assign fall = en_q & ~en;

  always_comb begin
    sh_nx  = sh_q;
    val_nx = val_q;
    if (en)   sh_nx  = {sh_q[W-2:0], sin};
    if (fall) val_nx = sh_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      val_q  <= '0;
      en_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      sh_q   <= sh_nx;
      val_q  <= val_nx;
      en_q   <= en;
      done_q <= fall;
    end
  end

  assign done = done_q;
  assign val  = val_q;
endmodule

// File: rtl/tlm_mbox_rd.sv
module tlm_mbox_rd #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DEPTH  = 128
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_evt,
  input  logic                          wr_ok,
  input  logic [ADDR_W-1:0]             wr_addr,
  input  logic [DATA_W-1:0]             wr_data,
  input  logic                          frame_start,
  input  logic                          rd_req,
  output logic [DATA_W/2-1:0]           out_byte,
  output logic                          out_valid,
  output logic [$clog2(DEPTH):0]        ptr_o,
  output logic                          silent_o,
  output logic                          act_o
);
  localparam int unsigned BYTE_W = DATA_W / 2;
  localparam int unsigned IDX_W  = $clog2(DEPTH);
  localparam int unsigned PTR_W  = IDX_W + 1;
  localparam logic [BYTE_W-1:0] FILL = {(BYTE_W/2){2'b10}};

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  ptr_q, ptr_nx, idx;
  logic [DATA_W-1:0] word_q;
  logic              hi_q, fill_q, valid_q;
  logic              act_q, act_nx, silent_q, silent_nx;
  logic              commit;

  assign commit = wr_evt & wr_ok;
  assign idx    = frame_start ? '0 : ptr_q;

  always_comb begin
    ptr_nx    = rd_req ? idx + 1'b1 : idx;
    act_nx    = frame_start ? commit : (act_q | commit);
    silent_nx = silent_q;
    if (frame_start) silent_nx = ~act_q;
    if (commit)      silent_nx = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (commit) begin
      mem[wr_addr[IDX_W-1:0]] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q    <= '0;
      word_q   <= '0;
      hi_q     <= 1'b1;
      fill_q   <= 1'b1;
      valid_q  <= 1'b0;
      act_q    <= 1'b0;
      silent_q <= 1'b1;
    end else begin
      ptr_q    <= ptr_nx;
      act_q    <= act_nx;
      silent_q <= silent_nx;
      valid_q  <= rd_req;
      if (rd_req) begin
        word_q <= mem[idx[PTR_W-1:1]];
        hi_q   <= ~idx[0];
        fill_q <= silent_nx;
      end
    end
  end

  always_comb begin
    if (fill_q || (word_q == '0)) out_byte = FILL;
    else if (hi_q)                out_byte = word_q[DATA_W-1:BYTE_W];
    else                          out_byte = word_q[BYTE_W-1:0];
  end

  assign out_valid = valid_q;
  assign ptr_o     = ptr_q;
  assign silent_o  = silent_q;
  assign act_o     = act_q;
endmodule

// File: rtl/tlm_mailbox.sv
module tlm_mailbox
  import tlm_mbox_pkg::*;
#(
  parameter int unsigned DATA_W = MB_DATA_W,
  parameter int unsigned ADDR_W = MB_ADDR_W,
  parameter int unsigned DEPTH  = MB_DEPTH
) (
  input  logic                wclk,
  input  logic                wrst_n,
  input  logic                data_sin,
  input  logic                data_en,
  input  logic                addr_sin,
  input  logic                addr_en,
  input  logic                rclk,
  input  logic                rrst_n,
  input  logic                frame_start,
  input  logic                rd_req,
  output logic [DATA_W/2-1:0] out_byte,
  output logic                out_valid
);
  localparam int unsigned PTR_W = $clog2(DEPTH) + 1;

  logic              w_rst_n, r_rst_n;
  logic              d_done, a_done;
  logic [DATA_W-1:0] d_val;
  logic [ADDR_W-1:0] a_val;
  logic [ADDR_W-1:0] addr_q, addr_nx, hold_a_q, hold_a_nx;
  logic [DATA_W-1:0] hold_d_q, hold_d_nx;
  logic              tog_q, tog_nx;
  logic              s1_q, s2_q, s3_q;
  logic              evt, wr_ok;
  logic [PTR_W-1:0]  ptr;
  logic              silent, act;

  tlm_rst_sync u_wrst (.clk(wclk), .arst_n(wrst_n), .rst_n(w_rst_n));
  tlm_rst_sync u_rrst (.clk(rclk), .arst_n(rrst_n), .rst_n(r_rst_n));

  tlm_deser #(.W(DATA_W)) u_dser (
    .clk(wclk), .rst_n(w_rst_n), .sin(data_sin), .en(data_en),
    .done(d_done), .val(d_val));
  tlm_deser #(.W(ADDR_W)) u_aser (
    .clk(wclk), .rst_n(w_rst_n), .sin(addr_sin), .en(addr_en),
    .done(a_done), .val(a_val));

  always_comb begin
    addr_nx   = a_done ? a_val : addr_q;
    hold_a_nx = hold_a_q;
    hold_d_nx = hold_d_q;
    tog_nx    = tog_q;
    if (d_done) begin
      hold_a_nx = addr_nx;
      hold_d_nx = d_val;
      tog_nx    = ~tog_q;
    end
  end

  always_ff @(posedge wclk or negedge w_rst_n) begin
    if (!w_rst_n) begin
      addr_q   <= '0;
      hold_a_q <= '0;
      hold_d_q <= '0;
      tog_q    <= 1'b0;
    end else begin
      addr_q   <= addr_nx;
      hold_a_q <= hold_a_nx;
      hold_d_q <= hold_d_nx;
      tog_q    <= tog_nx;
    end
  end

  always_ff @(posedge rclk or negedge r_rst_n) begin
    if (!r_rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= tog_q;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign evt   = s2_q ^ s3_q;
  assign wr_ok = ({1'b0, hold_a_q} < (ADDR_W+1)'(DEPTH));

  tlm_mbox_rd #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_rd (
    .clk(rclk), .rst_n(r_rst_n), .wr_evt(evt), .wr_ok(wr_ok),
    .wr_addr(hold_a_q), .wr_data(hold_d_q), .frame_start(frame_start),
    .rd_req(rd_req), .out_byte(out_byte), .out_valid(out_valid),
    .ptr_o(ptr), .silent_o(silent), .act_o(act));
endmodule

// File: rtl/tlm_mailbox_chk.sv
module tlm_mailbox_chk #(
  parameter int unsigned PTR_W  = 8,
  parameter int unsigned BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_start,
  input logic              rd_req,
  input logic              out_valid,
  input logic [BYTE_W-1:0] out_byte,
  input logic [PTR_W-1:0]  ptr,
  input logic              silent,
  input logic              act,
  input logic              evt,
  input logic              wr_ok
);
  localparam logic [BYTE_W-1:0] FILL = {(BYTE_W/2){2'b10}};

  assert_valid_after_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> out_valid);
  assert_no_valid_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !out_valid);
  assert_byte_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> $stable(out_byte));
  assert_frame_ptr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> ptr == PTR_W'($past(rd_req)));
  assert_silent_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && silent && !(evt && wr_ok) && !frame_start) |=> out_byte == FILL);
  assert_bad_addr_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && !wr_ok && !act && !frame_start) |=> !act);
endmodule

bind tlm_mailbox tlm_mailbox_chk #(.PTR_W(PTR_W), .BYTE_W(DATA_W/2)) u_chk (
  .clk(rclk), .rst_n(r_rst_n), .frame_start(frame_start), .rd_req(rd_req),
  .out_valid(out_valid), .out_byte(out_byte), .ptr(ptr), .silent(silent),
  .act(act), .evt(evt), .wr_ok(wr_ok));

// File: tb/tlm_mailbox_bench.sv
module tlm_mailbox_bench;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       arst_n;
  logic       data_sin, data_en, addr_sin, addr_en, frame_start, rd_req;
  logic [7:0] out_byte;
  logic       out_valid;
  int         n_tests = 0, n_fail = 0, bptr = 0;
  bit         finished = 1'b0;

  tlm_mailbox u_tlm_mailbox (
    .wclk(clk), .wrst_n(arst_n), .data_sin(data_sin), .data_en(data_en),
    .addr_sin(addr_sin), .addr_en(addr_en), .rclk(clk), .rrst_n(arst_n),
    .frame_start(frame_start), .rd_req(rd_req), .out_byte(out_byte),
    .out_valid(out_valid));

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic shift_field(input logic [15:0] v, input int n, input bit to_addr);
    for (int i = n - 1; i >= 0; i--) begin
      @(negedge clk);
      if (to_addr) begin addr_en = 1'b1; addr_sin = v[i]; end
      else         begin data_en = 1'b1; data_sin = v[i]; end
      @(posedge clk);
    end
    @(negedge clk);
    addr_en = 1'b0; data_en = 1'b0; addr_sin = 1'b0; data_sin = 1'b0;
  endtask

  task automatic write_word(input logic [7:0] a, input logic [15:0] d);
    shift_field({8'h00, a}, 8, 1'b1);
    shift_field(d, 16, 1'b0);
    repeat (8) @(posedge clk);
  endtask

  task automatic write_data_only(input logic [15:0] d);
    shift_field(d, 16, 1'b0);
    repeat (8) @(posedge clk);
  endtask

  task automatic rd(output logic [7:0] b, output logic v, input bit fs);
    @(negedge clk); rd_req = 1'b1; frame_start = fs;
    @(posedge clk);
    @(negedge clk); rd_req = 1'b0; frame_start = 1'b0;
    b = out_byte; v = out_valid;
    bptr = fs ? 1 : (bptr + 1) % 256;
  endtask

  task automatic seek(input int pos);
    logic [7:0] b; logic v;
    while (bptr != pos) rd(b, v, 1'b0);
  endtask

  task automatic read_word(input int slot, input logic [15:0] exp, input string req);
    logic [7:0] b; logic v;
    seek(2 * slot);
    rd(b, v, 1'b0); check(req, b, exp[15:8]);
    rd(b, v, 1'b0); check(req, b, exp[7:0]);
  endtask

  task automatic fs_only();
    @(negedge clk); frame_start = 1'b1;
    @(posedge clk);
    @(negedge clk); frame_start = 1'b0;
    bptr = 0;
  endtask

  task automatic t_reset();
    check("R3 reset valid", {7'b0, out_valid}, 8'h00);
    check("R6 reset fill", out_byte, 8'hAA);
  endtask

  task automatic t_basic();
    logic [7:0] b; logic v;
    write_word(8'd3, 16'h12AB);
    seek(6);
    rd(b, v, 1'b0); check("R1 R2 high byte", b, 8'h12);
    check("R3 valid", {7'b0, v}, 8'h01);
    rd(b, v, 1'b0); check("R3 low byte", b, 8'hAB);
    @(negedge clk);
    check("R3 valid drops", {7'b0, out_valid}, 8'h00);
    check("R3 byte held", out_byte, 8'hAB);
  endtask

  task automatic t_addr_reuse();
    write_data_only(16'h0034);
    read_word(3, 16'h0034, "R2 R5 reused address, zero byte kept");
  endtask

  task automatic t_zero();
    write_word(8'd4, 16'h0000);
    read_word(4, 16'hAAAA, "R5 zero word fill");
  endtask

  task automatic t_high_addr();
    write_word(8'h83, 16'hFFFF);
    read_word(3, 16'h0034, "R7 out of range dropped");
  endtask

  task automatic t_frame();
    logic [7:0] b; logic v;
    write_word(8'd0, 16'h5A5B);
    seek(9);
    rd(b, v, 1'b1); check("R4 frame start pos 0", b, 8'h5A);
    rd(b, v, 1'b0); check("R4 next pos 1", b, 8'h5B);
  endtask

  task automatic t_silent();
    fs_only();
    read_word(0, 16'hAAAA, "R6 silent window fill");
    write_word(8'h90, 16'h1234);
    read_word(0, 16'hAAAA, "R7 dropped write not activity");
    write_word(8'd1, 16'h7777);
    read_word(0, 16'h5A5B, "R6 fill cleared by write");
    read_word(1, 16'h7777, "R6 new word");
  endtask

  task automatic t_wrap();
    logic [7:0] b; logic v;
    seek(254);
    rd(b, v, 1'b0); check("R3 pos 254", b, 8'hAA);
    rd(b, v, 1'b0); check("R3 pos 255", b, 8'hAA);
    rd(b, v, 1'b0); check("R3 wrap to 0", b, 8'h5A);
  endtask

  task automatic t_collision();
    shift_field(16'h0000, 8, 1'b1);
    repeat (4) @(posedge clk);
    shift_field(16'h2233, 16, 1'b0);
    repeat (4) @(posedge clk);
    @(negedge clk); rd_req = 1'b1; frame_start = 1'b1;
    @(posedge clk);
    @(negedge clk); frame_start = 1'b0;
    check("R8 collision old high", out_byte, 8'h5A);
    @(posedge clk);
    @(negedge clk); rd_req = 1'b0;
    check("R8 next read new low", out_byte, 8'h33);
    bptr = 2;
    read_word(0, 16'h2233, "R8 new word stored");
  endtask

  initial begin
    arst_n = 1'b1; data_sin = 1'b0; data_en = 1'b0; addr_sin = 1'b0;
    addr_en = 1'b0; frame_start = 1'b0; rd_req = 1'b0;
    #1 arst_n = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk) arst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    t_reset();
    t_basic();
    t_addr_reuse();
    t_zero();
    t_high_addr();
    t_frame();
    t_silent();
    t_wrap();
    t_collision();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule